// File: doc/BRIEF.md
# I2C Bus Inactivity Watchdog with Stuck-Bus Recovery

This block sits beside the I2C pins of a device and watches the bus for silence after a transfer has been cut off midway. It synchronises the raw SCL and SDA levels into the system clock domain and treats any change on either line as bus signaling. Each change restarts an inactivity timer. The timer has two lengths, picked by a speed-up control input: about one second, or about fifty microseconds. Both lengths are derived from the system clock frequency parameter. A separate parameter can replace the one-second count with a small value for simulation.

When the timer runs out, the block looks at the synchronised SDA level. If SDA is high, the bus is declared free. If SDA is low, a slave is assumed to be holding it, and the block sends up to nine clock pulses on SCL by pulling the line low and releasing it. Each pulse has a low half and a released half of equal length, set by a recovery clock-rate parameter. SDA is checked at the end of every released half. If SDA is found high there, recovery stops early and the bus is declared free. A disable input turns the whole watchdog off.

Top module: `i2c_bus_watchdog`

## Requirements
- R1: SCL and SDA each pass through a two-flop synchronizer. A level change on either line becomes a detected edge one cycle after it leaves the second flop. Outside recovery, a detected edge resets the quiet count to zero and clears `bus_free`.
- R2: With `wd_fast`=0, `timeout_pulse` goes high for exactly one cycle after LONG consecutive clock edges with no detected edge. LONG is `LONG_OVERRIDE` when that is non-zero, and `CLK_HZ` otherwise. The quiet count then restarts from zero.
- R3: With `wd_fast`=1, the expiry of R2 happens after CLK_HZ/20000 quiet edges, which is 50 us.
- R4: If the synchronised SDA is 1 at expiry, `bus_free` is set. It stays set until the next detected edge, and further expiries leave it set.
- R5: If the synchronised SDA is 0 at expiry, `recovering` and `scl_pull_low` rise together with the timeout pulse. Recovery then makes pulses of HALF=CLK_HZ/(2*RECOVERY_SCL_HZ) cycles pulled low followed by HALF cycles released, at most PULSES (9) low phases in all.
- R6: At the last cycle of each released half, SDA is checked. If it is 1, recovery ends, `bus_free` is set and `scl_pull_low` stays 0. If it is 0 after the ninth pulse, recovery ends with `bus_free`=0.
- R7: Edges detected while recovering, including those the block's own pulses cause, are ignored. The quiet count restarts from zero when recovery ends.
- R8: While `wd_disable`=1, from the next clock edge on: no timeout pulse, `bus_free`=0, `recovering`=0, `scl_pull_low`=0. A recovery that is running is aborted.
- R9: The asynchronous active-low reset clears all four outputs and the quiet count. The synchronizers reset to the idle-high level.
- R10: `scl_pull_low` is an open-drain enable. It is 1 only while `recovering` is 1. The block never drives SCL high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL pad level, asynchronous |
| sda_in | input | 1 | SDA pad level, asynchronous |
| wd_disable | input | 1 | 1 turns the watchdog off |
| wd_fast | input | 1 | 1 selects the 50 us timeout, 0 selects the long timeout |
| scl_pull_low | output | 1 | 1 pulls SCL low; 0 releases it |
| bus_free | output | 1 | Bus declared idle after a quiet timeout with SDA high |
| recovering | output | 1 | Recovery clock burst in progress |
| timeout_pulse | output | 1 | One-cycle pulse at each timer expiry |

## Verification
Two events can land on the same clock edge. A bus edge can arrive exactly when the quiet count reaches its limit, and SDA can rise exactly at the end of a released half in recovery. The bench sweeps a single SCL toggle across the cycles on both sides of the fast limit. It also lets a simulated stuck slave release SDA after a chosen number of recovery pulses. A behavioural reference model judges every cycle: an edge on the limit cycle must suppress the timeout, and a release must end recovery on the next released-half boundary.

// File: rtl/i2c_bus_watchdog.sv
module i2c_bus_watchdog #(
  parameter int CLK_HZ          = 50_000_000,
  parameter int LONG_OVERRIDE   = 0,
  parameter int RECOVERY_SCL_HZ = 100_000,
  parameter int PULSES          = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wd_disable,
  input  logic wd_fast,
  output logic scl_pull_low,
  output logic bus_free,
  output logic recovering,
  output logic timeout_pulse
);

  localparam int LONG_CYCLES  = (LONG_OVERRIDE != 0) ? LONG_OVERRIDE : CLK_HZ;
  localparam int SHORT_CYCLES = (CLK_HZ / 20_000 < 2) ? 2 : CLK_HZ / 20_000;
  localparam int HALF         = (CLK_HZ / (2 * RECOVERY_SCL_HZ) < 3) ? 3 : CLK_HZ / (2 * RECOVERY_SCL_HZ);
  localparam int CW           = $clog2(LONG_CYCLES + SHORT_CYCLES + 1);
  localparam int HW           = $clog2(HALF) + 1;
  localparam int PW           = $clog2(PULSES) + 1;
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_CYCLES - 1);

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  logic [CW-1:0] cnt;
  logic [HW-1:0] ph;
  logic [PW-1:0] pc;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire activity = (scl_s ^ scl_q) | (sda_s ^ sda_q);
  wire expired  = cnt >= (wd_fast ? SHORT_M1 : LONG_M1);
  wire half_end = ph == HW'(HALF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      ph            <= '0;
      pc            <= '0;
      scl_pull_low  <= 1'b0;
      bus_free      <= 1'b0;
      recovering    <= 1'b0;
      timeout_pulse <= 1'b0;
    end else begin
      timeout_pulse <= 1'b0;
      if (wd_disable) begin
        cnt          <= '0;
        bus_free     <= 1'b0;
        recovering   <= 1'b0;
        scl_pull_low <= 1'b0;
      end else if (recovering) begin
        if (!half_end) begin
          ph <= ph + 1'b1;
        end else begin
          ph <= '0;
          if (scl_pull_low) begin
            scl_pull_low <= 1'b0;
          end else if (sda_s || pc == PW'(PULSES - 1)) begin
            recovering <= 1'b0;
            bus_free   <= sda_s;
            cnt        <= '0;
          end else begin
            scl_pull_low <= 1'b1;
            pc           <= pc + 1'b1;
          end
        end
      end else if (activity) begin
        cnt      <= '0;
        bus_free <= 1'b0;
      end else if (expired) begin
        cnt           <= '0;
        timeout_pulse <= 1'b1;
        if (sda_s) begin
          bus_free <= 1'b1;
        end else begin
          recovering   <= 1'b1;
          scl_pull_low <= 1'b1;
          ph           <= '0;
          pc           <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Guard logic: low phases counted per recovery burst
  logic [PW:0] chk_lows;
  logic        chk_pull_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_lows   <= '0;
      chk_pull_q <= 1'b0;
    end else begin
      chk_pull_q <= scl_pull_low;
      if (!recovering)                    chk_lows <= '0;
      else if (scl_pull_low && !chk_pull_q) chk_lows <= chk_lows + 1'b1;
    end
  end

  assert_pull_only_in_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> recovering);
  assert_disable_quiets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_disable |=> (!recovering && !bus_free && !timeout_pulse && !scl_pull_low));
  assert_single_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);
  assert_start_with_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovering) |-> (timeout_pulse && scl_pull_low));
  assert_free_excludes_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_free && recovering));
  assert_pulse_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_lows <= (PW+1)'(PULSES));
  assert_edge_clears_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (activity && !recovering && !wd_disable) |=> !bus_free);

endmodule

// File: tb/i2c_bus_watchdog_tb.sv
module i2c_bus_watchdog_tb;
  localparam int LIM_LONG = 400;
  localparam int LIM_FAST = 50;
  localparam int H        = 5;
  localparam int NP       = 9;

  logic clk = 0, rst_n = 0;
  logic scl_drv = 1, sda_drv = 1, slave_low = 0;
  logic wd_disable = 0, wd_fast = 0;
  logic scl_pull_low, bus_free, recovering, timeout_pulse;
  wire  scl_line = scl_drv & ~scl_pull_low;
  wire  sda_line = sda_drv & ~slave_low;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int release_after = 0, falls = 0, pulses_seen = 0;
  logic scl_prev = 1, rec_prev = 0, pull_prev = 0;

  always #10 clk = ~clk;

  i2c_bus_watchdog #(.CLK_HZ(1_000_000), .LONG_OVERRIDE(LIM_LONG),
                     .RECOVERY_SCL_HZ(100_000), .PULSES(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .wd_disable(wd_disable), .wd_fast(wd_fast), .scl_pull_low(scl_pull_low),
    .bus_free(bus_free), .recovering(recovering), .timeout_pulse(timeout_pulse));

  // behavioural reference
  int m_s1, m_s2, m_sp, m_d1, m_d2, m_dp, quiet, rt;
  int m_free, m_rec, m_pull, m_to;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_sp = 1; m_d1 = 1; m_d2 = 1; m_dp = 1;
      quiet = 0; rt = 0; m_free = 0; m_rec = 0; m_pull = 0; m_to = 0;
    end else begin
      bit act;
      int lim;
      act = (m_s2 != m_sp) || (m_d2 != m_dp);
      m_to = 0;
      if (wd_disable) begin
        quiet = 0; m_free = 0; m_rec = 0; m_pull = 0;
      end else if (m_rec != 0) begin
        if (rt % (2*H) == 2*H-1 && (m_d2 == 1 || rt / (2*H) == NP-1)) begin
          m_rec = 0; m_pull = 0; m_free = m_d2; quiet = 0;
        end else begin
          rt++;
          m_pull = (rt % (2*H)) < H;
        end
      end else if (act) begin
        quiet = 0; m_free = 0;
      end else begin
        quiet++;
        lim = wd_fast ? LIM_FAST : LIM_LONG;
        if (quiet >= lim) begin
          quiet = 0; m_to = 1;
          if (m_d2 == 1) m_free = 1;
          else begin m_rec = 1; rt = 0; m_pull = 1; end
        end
      end
      m_sp = m_s2; m_s2 = m_s1; m_s1 = int'(scl_line);
      m_dp = m_d2; m_d2 = m_d1; m_d1 = int'(sda_line);
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 scl_pull_low", int'(scl_pull_low), m_pull);
      chk("R4 bus_free", int'(bus_free), m_free);
      chk("R5 recovering", int'(recovering), m_rec);
      chk("R2 timeout_pulse", int'(timeout_pulse), m_to);
    end
    if (recovering && !rec_prev) pulses_seen = 0;
    if (scl_pull_low && !pull_prev) pulses_seen++;
    rec_prev = recovering; pull_prev = scl_pull_low;
    if (slave_low && scl_prev && !scl_line) begin
      falls++;
      if (release_after != 0 && falls >= release_after) slave_low = 0;
    end
    scl_prev = scl_line;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rec_end(string tag);
    int guard = 0;
    while (!recovering && guard < 2000) begin cyc(1); guard++; end
    while (recovering && guard < 4000) begin cyc(1); guard++; end
    chk({tag, " recovery ended"}, guard < 4000, 1);
  endtask

  initial begin
    cyc(3);
    chk("R9 reset pull", int'(scl_pull_low), 0);
    chk("R9 reset free", int'(bus_free), 0);
    chk("R9 reset rec", int'(recovering), 0);
    rst_n = 1;
    // R2 long timeout, SDA high -> R4
    cyc(LIM_LONG + 10);
    chk("R4 free after long quiet", int'(bus_free), 1);
    sda_drv = 0; cyc(1); sda_drv = 1; cyc(6);
    chk("R1 edge clears free", int'(bus_free), 0);
    // R3 fast timeout, R11-like repeat with free held
    wd_fast = 1;
    cyc(LIM_FAST * 3 + 10);
    chk("R3 free after fast quiet", int'(bus_free), 1);
    // R1 activity keeps timer from expiring
    for (int i = 0; i < 10; i++) begin scl_drv = ~scl_drv; cyc(30); end
    scl_drv = 1; cyc(8);
    chk("R1 no free under activity", int'(bus_free), 0);
    // same-cycle sweep: edge vs expiry
    for (int off = LIM_FAST - 6; off <= LIM_FAST + 4; off++) begin
      scl_drv = 0; cyc(1); scl_drv = 1; cyc(off);
      scl_drv = 0; cyc(1); scl_drv = 1; cyc(3);
    end
    cyc(80);
    // R5 stuck SDA, full burst
    slave_low = 1; release_after = 0; falls = 0;
    wait_rec_end("R5");
    chk("R5 nine low phases", pulses_seen, NP);
    chk("R6 not free while SDA low", int'(bus_free), 0);
    // R7 timer restarts after exit: next recovery starts after full quiet period
    cyc(LIM_FAST - 5);
    chk("R7 no new recovery yet", int'(recovering), 0);
    // R6 early stop after three pulses
    cyc(40);
    while (recovering) cyc(1);
    falls = 0; release_after = 3; slave_low = 1;
    wait_rec_end("R6");
    chk("R6 early stop pulse count", pulses_seen, 3);
    chk("R6 free after early stop", int'(bus_free), 1);
    // R8 disable aborts recovery
    release_after = 0; falls = 0; slave_low = 1;
    begin
      int g = 0;
      while (!recovering && g < 500) begin cyc(1); g++; end
    end
    cyc(12);
    wd_disable = 1; cyc(2);
    chk("R8 abort recovery", int'(recovering), 0);
    chk("R8 scl released", int'(scl_pull_low), 0);
    cyc(LIM_LONG + 20);
    chk("R8 no recovery while disabled", int'(recovering), 0);
    slave_low = 0; cyc(20);
    chk("R8 no free while disabled", int'(bus_free), 0);
    wd_disable = 0; cyc(LIM_FAST + 10);
    chk("R4 free after enable", int'(bus_free), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule